// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This controller collects seventeen interrupt sources and offers the most urgent one to a processor core. It presents the source code and the entry address of its handler, then waits for the core to take it. Two sources stand above every numbered slot: the emulator request and the reset request. Below them are fifteen numbered slots. Slot 0 is power-down, slot 1 is the loop/stack fault and slot 2 is the debug kernel. Slots 3 to 14 are twelve user slots. Peripheral request lines reach the user slots through a programmable assignment stage. Each peripheral owns a 4-bit field that names its user slot. Several peripherals that name the same slot are ORed together.

Every source has a pending bit and a mask bit, and both use the same bit positions. Bit 0 is the emulator, bit 1 is reset and bit k+2 is slot k. A pending bit sets while its source is high. It clears when the core acknowledges that source, or when software writes a 1 to it. The emulator, reset and power-down sources ignore the mask. The control loop has two states. In IDLE it waits for an eligible source. The IDLE-to-OFFER transition captures the winner and raises the request. The OFFER-to-IDLE transition happens on acknowledge, clears the winner's pending bit and drops the request. The offer stays frozen while the core has not acknowledged.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, core_req is 0, the mask and pending registers read 0, and every peripheral map field reads 4'hF.
- R2: A high source input sets its pending bit (bit 0 emulator, bit 1 reset, bit k+2 slot k) at the next clock edge. The bit stays set after the input falls.
- R3: Among eligible sources, the emulator wins over reset, reset wins over slot 0, and slot k wins over slot k+1.
- R4: core_src is 0 for the emulator, 1 for reset and k+2 for slot k. core_vec is 12'h3E0 for the emulator, 12'h3C0 for reset and k*0x20 for slot k.
- R5: A mask bit of 0 keeps pending slots 1 to 14 out of arbitration. The emulator, reset and slot 0 are offered whatever their mask bits hold.
- R6: A peripheral map value v in 0..11 routes that peripheral to slot v+3. Values 12..15 disconnect it. Peripherals that share a slot are ORed.
- R7: From IDLE, core_req rises on the second clock edge after a source input rises. While core_ack is low, core_req, core_src and core_vec hold, even when a more urgent source arrives.
- R8: core_ack while core_req is high clears the offered pending bit at that edge, and core_req is low in the next cycle. A source still held high re-latches, because setting wins over clearing.
- R9: Writing the pending register (select 1) clears exactly the bits written as 1. Bits written as 0 keep their state.
- R10: reg_rdata returns the mask for select 0, the pending bits for select 1 and the map field of peripheral reg_idx for select 2. Select 3 returns zero. Writes with select 0 load the mask, and writes with select 2 load a map field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| emu_req | input | 1 | Emulator request, highest, unmaskable |
| rst_req | input | 1 | Reset request, unmaskable |
| sys_req | input | 3 | Slots 0..2: power-down (unmaskable), stack fault, debug kernel |
| periph_req | input | 16 | Peripheral request lines |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 mask, 1 pending, 2 map, 3 none |
| reg_idx | input | 4 | Peripheral index for map access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| core_req | output | 1 | Registered interrupt request to the core |
| core_src | output | 5 | Offered source code |
| core_vec | output | 12 | Handler address |
| core_ack | input | 1 | Core takes the offered interrupt |

## Verification
The bench targets several corner cases, and each one exposes a specific fault.
- Priority ties: a design that scans from the wrong end would offer a user slot ahead of the emulator.
- Masked requests: a design that lets the mask gate power-down would go silent on a masked slot 0. One that skips the mask would offer a masked stack fault.
- Shared and disconnected map values: OR-merging or out-of-range decoding faults show up as a wrong slot number or a phantom request.
- Late urgent source: an emulator request arriving during an unacknowledged offer must leave the vector unchanged.
- Held source at acknowledge: a design where clearing beats setting would lose a source that is still high.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
    typedef enum logic [0:0] {
        S_IDLE  = 1'b0,
        S_OFFER = 1'b1
    } ctl_state_t;

    typedef enum logic [1:0] {
        SEL_MASK = 2'd0,
        SEL_PEND = 2'd1,
        SEL_MAP  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_t;

    localparam int TOP_SRCS = 2;  // emulator, reset
    localparam int SYS_SLOTS = 3; // power-down, stack fault, debug kernel
    localparam int NMI_SRCS = 3;  // positions that ignore the mask
endpackage

// File: rtl/irq_slot_map.sv
module irq_slot_map #(
    parameter int NUM_PERIPH = 16,
    parameter int NUM_USER   = 12,
    parameter int MAP_W      = 4,
    parameter int IDX_W      = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   map_we,
    input  logic [IDX_W-1:0]       map_idx,
    input  logic [MAP_W-1:0]       map_wdata,
    input  logic [NUM_PERIPH-1:0]  periph_req,
    output logic [NUM_USER-1:0]    user_req,
    output logic [MAP_W-1:0]       map_rdata
);
    logic [MAP_W-1:0] map_q [NUM_PERIPH];

    generate
        for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_field
            always_ff @(posedge clk) begin
                if (!rst_n)
                    map_q[p] <= '1;
                else if (map_we && (int'(map_idx) == p))
                    map_q[p] <= map_wdata;
            end
        end
        for (genvar u = 0; u < NUM_USER; u++) begin : g_merge
            always_comb begin
                user_req[u] = 1'b0;
                for (int p = 0; p < NUM_PERIPH; p++)
                    if (int'(map_q[p]) == u)
                        user_req[u] = user_req[u] | periph_req[p];
            end
        end
    endgenerate

    assign map_rdata = (int'(map_idx) < NUM_PERIPH) ? map_q[map_idx] : '0;

    // R6: a slot can only be requested when some peripheral line is high
    p_merge_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (user_req != '0) |-> (periph_req != '0));
endmodule

// File: rtl/irq_pend_regs.sv
module irq_pend_regs #(
    parameter int NUM_SRC = 17,
    parameter int NMI_N   = 3,
    parameter int SRC_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_set,
    input  logic               ack_fire,
    input  logic [SRC_W-1:0]   ack_pos,
    input  logic               mask_we,
    input  logic [NUM_SRC-1:0] mask_wdata,
    input  logic               w1c_we,
    input  logic [NUM_SRC-1:0] w1c_data,
    output logic [NUM_SRC-1:0] pend_q,
    output logic [NUM_SRC-1:0] mask_q,
    output logic [NUM_SRC-1:0] elig
);
    localparam logic [NUM_SRC-1:0] NMI_BITS = NUM_SRC'((1 << NMI_N) - 1);

    logic [NUM_SRC-1:0] ack_oh;
    logic [NUM_SRC-1:0] clr_vec;

    always_comb begin
        ack_oh  = ack_fire ? (NUM_SRC'(1) << ack_pos) : '0;
        clr_vec = ack_oh | (w1c_we ? w1c_data : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            mask_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_vec) | src_set;
            if (mask_we)
                mask_q <= mask_wdata;
        end
    end

    assign elig = pend_q & (mask_q | NMI_BITS);

    // R8: an input held high survives any clear
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (src_set != '0) |=> ((pend_q & $past(src_set)) == $past(src_set)));
    // R8: acknowledged bit is gone when not re-requested
    p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && ((src_set & ack_oh) == '0)) |=> ((pend_q & $past(ack_oh)) == '0));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NUM_SRC = 17,
    parameter int SRC_W   = 5
) (
    input  logic [NUM_SRC-1:0] elig,
    output logic               any,
    output logic [SRC_W-1:0]   win
);
    always_comb begin
        any = 1'b0;
        win = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                any = 1'b1;
                win = SRC_W'(i);
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_USER   = 12,
    parameter int NUM_PERIPH = 16,
    parameter int MAP_W      = 4,
    parameter int IDX_W      = 4,
    parameter int REG_W      = 32,
    parameter int VEC_W      = 12,
    parameter int VEC_STRIDE = 32,
    parameter logic [11:0] EMU_VEC = 12'h3E0,
    parameter logic [11:0] RST_VEC = 12'h3C0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  emu_req,
    input  logic                  rst_req,
    input  logic [2:0]            sys_req,
    input  logic [NUM_PERIPH-1:0] periph_req,
    input  logic                  reg_we,
    input  logic [1:0]            reg_sel,
    input  logic [IDX_W-1:0]      reg_idx,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    output logic                  core_req,
    output logic [4:0]            core_src,
    output logic [VEC_W-1:0]      core_vec,
    input  logic                  core_ack
);
    localparam int NUM_SLOT = SYS_SLOTS + NUM_USER;
    localparam int NUM_SRC  = TOP_SRCS + NUM_SLOT;
    localparam int SRC_W    = 5;

    ctl_state_t         state_q, state_d;
    reg_sel_t           sel;
    logic [NUM_USER-1:0] user_req;
    logic [MAP_W-1:0]   map_rdata;
    logic [NUM_SRC-1:0] src_set, pend_q, mask_q, elig;
    logic               any, ack_fire, take;
    logic [SRC_W-1:0]   win;
    logic [SRC_W-1:0]   src_q;
    logic [VEC_W-1:0]   vec_q;
    logic               req_q;

    assign sel = reg_sel_t'(reg_sel);

    irq_slot_map #(
        .NUM_PERIPH(NUM_PERIPH), .NUM_USER(NUM_USER), .MAP_W(MAP_W), .IDX_W(IDX_W)
    ) u_map (
        .clk(clk), .rst_n(rst_n),
        .map_we(reg_we && (sel == SEL_MAP)),
        .map_idx(reg_idx),
        .map_wdata(reg_wdata[MAP_W-1:0]),
        .periph_req(periph_req),
        .user_req(user_req),
        .map_rdata(map_rdata)
    );

    assign src_set = {user_req, sys_req, rst_req, emu_req};

    irq_pend_regs #(.NUM_SRC(NUM_SRC), .NMI_N(NMI_SRCS), .SRC_W(SRC_W)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .src_set(src_set),
        .ack_fire(ack_fire),
        .ack_pos(src_q),
        .mask_we(reg_we && (sel == SEL_MASK)),
        .mask_wdata(reg_wdata[NUM_SRC-1:0]),
        .w1c_we(reg_we && (sel == SEL_PEND)),
        .w1c_data(reg_wdata[NUM_SRC-1:0]),
        .pend_q(pend_q),
        .mask_q(mask_q),
        .elig(elig)
    );

    irq_prio_pick #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_pick (
        .elig(elig), .any(any), .win(win)
    );

    function automatic logic [VEC_W-1:0] vec_of(input logic [SRC_W-1:0] s);
        if (s == SRC_W'(0))      return VEC_W'(EMU_VEC);
        else if (s == SRC_W'(1)) return VEC_W'(RST_VEC);
        else                     return VEC_W'((int'(s) - TOP_SRCS) * VEC_STRIDE);
    endfunction

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions: IDLE->OFFER on an eligible source, OFFER->IDLE on ack
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (any)      state_d = S_OFFER;
            S_OFFER: if (core_ack) state_d = S_IDLE;
            default:               state_d = S_IDLE;
        endcase
    end

    assign take     = (state_q == S_IDLE) && any;
    assign ack_fire = (state_q == S_OFFER) && core_ack;

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            src_q <= '0;
            vec_q <= '0;
        end else begin
            req_q <= (state_d == S_OFFER);
            if (take) begin
                src_q <= win;
                vec_q <= vec_of(win);
            end
        end
    end

    assign core_req = req_q;
    assign core_src = src_q;
    assign core_vec = vec_q;

    always_comb begin
        unique case (sel)
            SEL_MASK: reg_rdata = REG_W'(mask_q);
            SEL_PEND: reg_rdata = REG_W'(pend_q);
            SEL_MAP:  reg_rdata = REG_W'(map_rdata);
            default:  reg_rdata = '0;
        endcase
    end

    // R7: offer frozen until acknowledge
    p_offer_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req && !core_ack) |=> (core_req && $stable(core_src) && $stable(core_vec)));
    // R8: acknowledge drops the request
    p_ack_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req && core_ack) |=> !core_req);
    // R3: the offered source was eligible
    p_win_eligible_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_req) |-> ((($past(elig) >> core_src) & NUM_SRC'(1)) != '0));
    // R3: nothing more urgent was eligible
    p_no_higher_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_req) |-> (($past(elig) & ((NUM_SRC'(1) << core_src) - NUM_SRC'(1))) == '0));
    // R5: a maskable slot is only offered when its mask bit was 1
    p_mask_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(core_req) && (core_src >= SRC_W'(NMI_SRCS))) |->
            ((($past(mask_q) >> core_src) & NUM_SRC'(1)) != '0));
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        emu_req = 1'b0, rst_req = 1'b0;
    logic [2:0]  sys_req = '0;
    logic [15:0] periph_req = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [3:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        core_req;
    logic [4:0]  core_src;
    logic [11:0] core_vec;
    logic        core_ack = 1'b0;

    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .emu_req(emu_req), .rst_req(rst_req),
        .sys_req(sys_req), .periph_req(periph_req), .reg_we(reg_we),
        .reg_sel(reg_sel), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .core_req(core_req), .core_src(core_src),
        .core_vec(core_vec), .core_ack(core_ack)
    );

    // {emu, rst, sys[2:0], periph[15:0], mask[16:0], expected src (31 = none)}
    localparam logic [42:0] TBL [12] = '{
        {1'b1, 1'b1, 3'b111, 16'hFFFF, 17'h1FFFF, 5'd0},
        {1'b0, 1'b1, 3'b111, 16'hFFFF, 17'h1FFFF, 5'd1},
        {1'b0, 1'b0, 3'b110, 16'hFFFF, 17'h1FFFF, 5'd3},
        {1'b0, 1'b0, 3'b001, 16'h0000, 17'h00000, 5'd2},
        {1'b0, 1'b0, 3'b000, 16'h0001, 17'h1FFFF, 5'd5},
        {1'b0, 1'b0, 3'b000, 16'h0801, 17'h1FFDF, 5'd16},
        {1'b0, 1'b0, 3'b000, 16'h2000, 17'h1FFFF, 5'd31},
        {1'b0, 1'b0, 3'b000, 16'h1020, 17'h1FFFF, 5'd10},
        {1'b0, 1'b0, 3'b010, 16'h0008, 17'h1FFF7, 5'd8},
        {1'b0, 1'b0, 3'b110, 16'hFFFF, 17'h00007, 5'd31},
        {1'b0, 1'b1, 3'b000, 16'h0000, 17'h00000, 5'd1},
        {1'b0, 1'b0, 3'b000, 16'h0C00, 17'h1FFFF, 5'd15}
    };

    function automatic logic [11:0] exp_vec(input logic [4:0] s);
        if (s == 5'd0) return 12'h3E0;
        if (s == 5'd1) return 12'h3C0;
        return 12'((int'(s) - 2) * 32);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, input logic [3:0] idx, output logic [31:0] d);
        reg_sel = sel; reg_idx = idx;
        #1 d = reg_rdata;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 core_req", 32'(core_req), 0);
        rd(2'd0, 4'd0, d); check("R1 mask", d, 0);
        rd(2'd1, 4'd0, d); check("R1 pending", d, 0);
        rd(2'd2, 4'd7, d); check("R1 map", d, 32'hF);

        // map setup: p<12 -> user p, 12 -> user 5, 13 -> disconnected (14)
        for (int p = 0; p < 12; p++) wr(2'd2, 4'(p), 32'(p));
        wr(2'd2, 4'd12, 32'd5);
        wr(2'd2, 4'd13, 32'd14);
        rd(2'd2, 4'd12, d); check("R10 map readback", d, 32'd5);
        rd(2'd3, 4'd0, d);  check("R10 select 3", d, 0);

        // table walk: R3 R4 R5 R6
        for (int i = 0; i < 12; i++) begin
            logic [42:0] e;
            e = TBL[i];
            wr(2'd0, 4'd0, 32'(e[21:5]));
            emu_req = e[42]; rst_req = e[41]; sys_req = e[40:38]; periph_req = e[37:22];
            @(negedge clk);
            emu_req = 0; rst_req = 0; sys_req = 0; periph_req = 0;
            @(negedge clk);
            if (e[4:0] == 5'd31) begin
                check($sformatf("R5/R6 vector %0d no request", i), 32'(core_req), 0);
            end else begin
                check($sformatf("R3 vector %0d req", i), 32'(core_req), 1);
                check($sformatf("R3 vector %0d src", i), 32'(core_src), 32'(e[4:0]));
                check($sformatf("R4 vector %0d vec", i), 32'(core_vec), 32'(exp_vec(e[4:0])));
            end
            reg_we = 1'b1; reg_sel = 2'd1; reg_wdata = 32'h1FFFF;
            core_ack = core_req;
            @(negedge clk);
            reg_we = 1'b0; core_ack = 1'b0;
            @(negedge clk);
            check($sformatf("R8 vector %0d drained", i), 32'(core_req), 0);
        end

        // R2 / R5 / R9: latched while masked, write-one-to-clear
        wr(2'd0, 4'd0, 32'h0);
        @(negedge clk); periph_req = 16'h0001;
        @(negedge clk); periph_req = 16'h0;
        @(negedge clk);
        rd(2'd1, 4'd0, d); check("R2 pending bit 5", d, 32'h20);
        check("R5 masked no request", 32'(core_req), 0);
        wr(2'd1, 4'd0, 32'h0);
        rd(2'd1, 4'd0, d); check("R9 zero write keeps", d, 32'h20);
        wr(2'd1, 4'd0, 32'h20);
        rd(2'd1, 4'd0, d); check("R9 one write clears", d, 32'h0);

        // R7: latency and hold against a later emulator request
        wr(2'd0, 4'd0, 32'h1FFFF);
        @(negedge clk); sys_req = 3'b010;
        @(negedge clk); sys_req = 3'b000;
        check("R7 not yet after one edge", 32'(core_req), 0);
        @(negedge clk);
        check("R7 req after two edges", 32'(core_req), 1);
        emu_req = 1'b1;
        @(negedge clk); emu_req = 1'b0;
        check("R7 hold src", 32'(core_src), 32'd3);
        @(negedge clk);
        check("R7 hold vec", 32'(core_vec), 32'h20);
        core_ack = 1'b1;
        @(negedge clk); core_ack = 1'b0;
        check("R8 req low after ack", 32'(core_req), 0);
        @(negedge clk);
        check("R3 emulator next src", 32'(core_src), 32'd0);
        check("R4 emulator next vec", 32'(core_vec), 32'h3E0);
        core_ack = 1'b1;
        @(negedge clk); core_ack = 1'b0;
        @(negedge clk);
        check("R8 idle after second ack", 32'(core_req), 0);

        // R8: held source re-latches through acknowledge
        sys_req = 3'b010;
        @(negedge clk); @(negedge clk);
        check("R8 held offered", 32'(core_src), 32'd3);
        core_ack = 1'b1;
        @(negedge clk); core_ack = 1'b0;
        check("R8 gap after ack", 32'(core_req), 0);
        @(negedge clk);
        check("R8 re-offered", 32'(core_req), 1);
        sys_req = 3'b000; core_ack = 1'b1;
        @(negedge clk); core_ack = 1'b0;
        @(negedge clk);
        check("R8 final idle", 32'(core_req), 0);
        rd(2'd1, 4'd0, d); check("R8 pending empty", d, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule